// File: doc/BRIEF.md
# Variable-Page TLB Lookup Unit

This unit performs one translation lookup per request against a table of translation entries that is held elsewhere and presented to it as read-only input words. Each entry holds a virtual page number, a page-size code, a valid flag, an 8-bit owner tag, a real page number, write and execute rights and a zone selector. A request carries a virtual address, an access kind (read, write or instruction fetch) and a privilege flag. The unit compares the address against every entry at once, with each entry's compare width set by its own page size, which ranges from 1 KB to 16 MB. It then resolves which entry decides the outcome.

A 32-bit zone protection word gives each of sixteen zones a 2-bit code. The code can hide an entry from unprivileged code, leave the entry's own rights in force, or raise write and execute rights for privileged code only or for all code. The result is registered. It reports hit, miss or protection fault, the deciding entry's index and size code, and the translated physical address.

Top module: `vptlb_xlate`

## Requirements
- R1: The tag word of an entry stores the valid flag at bit 6, a page-size code at bits [9:7] and the virtual page number at bits [31:10]. Size code k selects a page of 1 KB times 4 to the power k, so codes 0 to 7 give 1K, 4K, 16K, 64K, 256K, 1M, 4M and 16M.
- R2: An entry is a candidate only if its valid flag is set and the request address equals the tag word in every bit at or above the page-offset width for that entry's size.
- R3: An entry with a nonzero owner tag is a candidate only when that tag equals cur_pid[7:0]. Bits [31:8] of cur_pid have no effect. An owner tag of zero matches any process ID.
- R4: The data word's bits [7:4] select a zone z. Its code is zone_prot[31-2z:30-2z], so zone 0 sits at [31:30]. A selector above ZONE_COUNT is treated as code 1, and so is every selector when the ZONES_EN parameter is 0.
- R5: The data word's bit 8 is the entry's own write right and bit 9 its own execute right. Code 0 makes the entry a non-candidate for unprivileged requests (req_user=1) and applies the own rights for privileged ones. Code 1 applies the own rights. Code 2 grants write and execute to privileged requests only. Code 3 grants both to all requests.
- R6: When several entries are candidates, the one with the lowest index decides the result.
- R7: req_acc is 0 for read, 1 for write, 2 for fetch, and 3 is handled as a read. A read is always allowed on the deciding entry. A write without the effective write right, or a fetch without the effective execute right, gives a protection fault, and no higher-index entry is considered.
- R8: rsp_status is 0 for miss, 1 for hit and 2 for protection fault, and never 3. On a miss, rsp_index, rsp_size and rsp_paddr are all zero. On a fault, rsp_index and rsp_size identify the deciding entry and rsp_paddr is zero.
- R9: On a hit, rsp_paddr takes the real page number (data word bits [31:10]) in the bits at and above the page-offset width and the request address in the bits below it. rsp_index and rsp_size identify the entry.
- R10: The result for a request sampled with req_vld high appears on the next cycle with rsp_vld high. rsp_vld is low in every cycle that follows a cycle without a request, and the result outputs then keep their previous values.
- R11: Synchronous reset clears rsp_vld, rsp_status, rsp_index, rsp_size and rsp_paddr to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| req_user | input | 1 | 1 for unprivileged, 0 for privileged |
| cur_pid | input | 32 | Current process ID; only bits [7:0] are used |
| zone_prot | input | 32 | Zone protection codes, 2 bits per zone |
| ent_tag | input | NUM_ENTRIES x 32 | Tag word of each entry |
| ent_data | input | NUM_ENTRIES x 32 | Data word of each entry |
| ent_tid | input | NUM_ENTRIES x 8 | Owner tag of each entry |
| rsp_vld | output | 1 | Result valid |
| rsp_status | output | 2 | 0 miss, 1 hit, 2 protection fault |
| rsp_index | output | log2(NUM_ENTRIES) | Deciding entry index |
| rsp_size | output | 3 | Deciding entry page-size code |
| rsp_paddr | output | 32 | Translated physical address |

## Verification
The hardest case to reach from the ports is a low-index entry that matches the address but must not decide the result, while a higher-index entry matches too. This happens when zone code 0 hides the low entry from an unprivileged request. It also happens when the low entry decides with a fault even though the higher entry would have allowed the access. The directed stimulus places two entries over the same virtual page at indices 10 and 20. It then changes only the zone word, the owner tags, the privilege flag and the access kind, so that each of these decisions is isolated. A second instance with zones disabled runs on every vector, so the zone-hiding case shows a divergent expected result on the same inputs. A randomized phase packs all entries onto a few shared pages with mixed sizes and owner tags, so that overlapping candidates are the normal case.

// File: rtl/vptlb_pkg.sv
package vptlb_pkg;

    localparam int ADDR_W      = 32;
    localparam int TID_W       = 8;
    localparam int SZ_W        = 3;
    localparam int ZSEL_W      = 4;
    localparam int ZCODE_W     = 2;
    localparam int MIN_PG_LG   = 10;
    localparam int VPN_W       = ADDR_W - MIN_PG_LG;

    // tag word layout
    localparam int TAG_VALID   = 6;
    localparam int TAG_SZ_LSB  = 7;
    // data word layout
    localparam int DAT_ZS_LSB  = 4;
    localparam int DAT_WR      = 8;
    localparam int DAT_EX      = 9;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        ST_MISS = 2'd0,
        ST_HIT  = 2'd1,
        ST_PROT = 2'd2
    } status_e;

    typedef enum logic [1:0] {
        ZN_HIDE_USER = 2'd0,
        ZN_OWN       = 2'd1,
        ZN_PRIV_RWX  = 2'd2,
        ZN_ALL_RWX   = 2'd3
    } zone_e;

    typedef struct packed {
        status_e             status;
        logic [SZ_W-1:0]     size;
        logic [ADDR_W-1:0]   paddr;
    } result_t;

    // keeps the address bits at and above the page-offset width
    function automatic logic [ADDR_W-1:0] page_mask(input logic [SZ_W-1:0] code);
        logic [ADDR_W-1:0] ones;
        ones = '1;
        return ones << (MIN_PG_LG + 2 * int'(code));
    endfunction

    // zone 0 occupies the two most significant bits
    function automatic logic [ZCODE_W-1:0] zone_field(input logic [ADDR_W-1:0] zp,
                                                      input logic [ZSEL_W-1:0] zs);
        return zp[ADDR_W - ZCODE_W - ZCODE_W * int'(zs) +: ZCODE_W];
    endfunction

endpackage

// File: rtl/vptlb_entry_cmp.sv
module vptlb_entry_cmp
    import vptlb_pkg::*;
#(
    parameter bit ZONES_EN   = 1'b1,
    parameter int ZONE_COUNT = 15
) (
    input  logic [VPN_W-1:0]  epn,
    input  logic [SZ_W-1:0]   size,
    input  logic              valid,
    input  logic [ZSEL_W-1:0] zsel,
    input  logic [TID_W-1:0]  tid,
    input  logic [TID_W-1:0]  pid_lo,
    input  logic [VPN_W-1:0]  vpn,
    input  logic [ADDR_W-1:0] zone_prot,
    input  logic              is_user,
    output logic              hit_cand,
    output zone_e             zone
);

    logic [ADDR_W-1:0] full_mask;
    logic [VPN_W-1:0]  vpn_mask;
    logic              addr_eq;
    logic              tid_ok;

    assign full_mask = page_mask(size);
    assign vpn_mask  = full_mask[ADDR_W-1:MIN_PG_LG];
    assign addr_eq   = ((epn ^ vpn) & vpn_mask) == '0;
    assign tid_ok    = (tid == '0) || (tid == pid_lo);

    generate
        if (ZONES_EN) begin : g_zones
            always_comb begin
                if (int'(zsel) > ZONE_COUNT)
                    zone = ZN_OWN;
                else
                    zone = zone_e'(zone_field(zone_prot, zsel));
            end
        end else begin : g_no_zones
            logic unused_zone_in;
            assign unused_zone_in = ^{zsel, zone_prot};
            assign zone = ZN_OWN;
        end
    endgenerate

    assign hit_cand = valid && addr_eq && tid_ok
                   && !(is_user && (zone == ZN_HIDE_USER));

endmodule

// File: rtl/vptlb_first_hit.sv
module vptlb_first_hit #(
    parameter  int N  = 64,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  grant
);

    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i])
                idx = IW'(i);
        end
    end

    // isolate the lowest set bit
    assign grant = req & (~req + {{(N-1){1'b0}}, 1'b1});

    always_comb begin
        if (found) begin
            p_grant_agrees_r6: assert (grant[idx] && $onehot(grant));
        end
    end

endmodule

// File: rtl/vptlb_rights.sv
module vptlb_rights
    import vptlb_pkg::*;
(
    input  logic    found,
    input  zone_e   zone,
    input  logic    own_wr,
    input  logic    own_ex,
    input  logic    is_user,
    input  acc_e    acc,
    output status_e status,
    output logic    eff_wr,
    output logic    eff_ex
);

    logic boost;

    always_comb begin
        boost  = (zone == ZN_ALL_RWX) || ((zone == ZN_PRIV_RWX) && !is_user);
        eff_wr = own_wr || boost;
        eff_ex = own_ex || boost;
        if (!found)
            status = ST_MISS;
        else if ((acc == ACC_WRITE) && !eff_wr)
            status = ST_PROT;
        else if ((acc == ACC_FETCH) && !eff_ex)
            status = ST_PROT;
        else
            status = ST_HIT;
    end

endmodule

// File: rtl/vptlb_xlate.sv
module vptlb_xlate
    import vptlb_pkg::*;
#(
    parameter  int NUM_ENTRIES = 64,
    parameter  bit ZONES_EN    = 1'b1,
    parameter  int ZONE_COUNT  = 12,
    localparam int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               req_vld,
    input  logic [31:0]                        req_vaddr,
    input  logic [1:0]                         req_acc,
    input  logic                               req_user,
    input  logic [31:0]                        cur_pid,
    input  logic [31:0]                        zone_prot,
    input  logic [NUM_ENTRIES-1:0][31:0]       ent_tag,
    input  logic [NUM_ENTRIES-1:0][31:0]       ent_data,
    input  logic [NUM_ENTRIES-1:0][7:0]        ent_tid,
    output logic                               rsp_vld,
    output logic [1:0]                         rsp_status,
    output logic [IDX_W-1:0]                   rsp_index,
    output logic [2:0]                         rsp_size,
    output logic [31:0]                        rsp_paddr
);

    logic [NUM_ENTRIES-1:0] cand;
    zone_e                  cand_zone [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] unused_rsvd;
    logic                   unused_pid_hi;

    // per-entry compare
    generate
        for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
            vptlb_entry_cmp #(
                .ZONES_EN   (ZONES_EN),
                .ZONE_COUNT (ZONE_COUNT)
            ) u_cmp (
                .epn       (ent_tag[g][ADDR_W-1:MIN_PG_LG]),
                .size      (ent_tag[g][TAG_SZ_LSB +: SZ_W]),
                .valid     (ent_tag[g][TAG_VALID]),
                .zsel      (ent_data[g][DAT_ZS_LSB +: ZSEL_W]),
                .tid       (ent_tid[g]),
                .pid_lo    (cur_pid[TID_W-1:0]),
                .vpn       (req_vaddr[ADDR_W-1:MIN_PG_LG]),
                .zone_prot (zone_prot),
                .is_user   (req_user),
                .hit_cand  (cand[g]),
                .zone      (cand_zone[g])
            );
            assign unused_rsvd[g] = ^{ent_tag[g][TAG_VALID-1:0], ent_data[g][DAT_ZS_LSB-1:0]};
        end
    endgenerate

    assign unused_pid_hi = ^cur_pid[ADDR_W-1:TID_W];

    // lowest index wins
    logic                   found;
    logic [IDX_W-1:0]       win_idx;
    logic [NUM_ENTRIES-1:0] grant;

    vptlb_first_hit #(.N(NUM_ENTRIES)) u_first (
        .req   (cand),
        .found (found),
        .idx   (win_idx),
        .grant (grant)
    );

    // select the winning entry's fields with the one-hot grant
    logic [VPN_W-1:0]   sel_rpn;
    logic [SZ_W-1:0]    sel_size;
    logic               sel_wr;
    logic               sel_ex;
    logic [ZCODE_W-1:0] sel_zone_bits;

    always_comb begin
        sel_rpn       = '0;
        sel_size      = '0;
        sel_wr        = 1'b0;
        sel_ex        = 1'b0;
        sel_zone_bits = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            sel_rpn       |= ent_data[i][ADDR_W-1:MIN_PG_LG] & {VPN_W{grant[i]}};
            sel_size      |= ent_tag[i][TAG_SZ_LSB +: SZ_W] & {SZ_W{grant[i]}};
            sel_wr        |= ent_data[i][DAT_WR] & grant[i];
            sel_ex        |= ent_data[i][DAT_EX] & grant[i];
            sel_zone_bits |= cand_zone[i] & {ZCODE_W{grant[i]}};
        end
    end

    // rights and status of the deciding entry
    status_e status_d;
    logic    eff_wr;
    logic    eff_ex;

    vptlb_rights u_rights (
        .found   (found),
        .zone    (zone_e'(sel_zone_bits)),
        .own_wr  (sel_wr),
        .own_ex  (sel_ex),
        .is_user (req_user),
        .acc     (acc_e'(req_acc)),
        .status  (status_d),
        .eff_wr  (eff_wr),
        .eff_ex  (eff_ex)
    );

    // result formation
    logic [ADDR_W-1:0] sel_mask;
    result_t           res_d;
    logic [IDX_W-1:0]  idx_d;

    always_comb begin
        sel_mask     = page_mask(sel_size);
        res_d.status = status_d;
        res_d.size   = found ? sel_size : '0;
        res_d.paddr  = '0;
        if (status_d == ST_HIT)
            res_d.paddr = ({sel_rpn, {MIN_PG_LG{1'b0}}} & sel_mask)
                        | (req_vaddr & ~sel_mask);
        idx_d = found ? win_idx : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld    <= 1'b0;
            rsp_status <= ST_MISS;
            rsp_index  <= '0;
            rsp_size   <= '0;
            rsp_paddr  <= '0;
        end else begin
            rsp_vld <= req_vld;
            if (req_vld) begin
                rsp_status <= res_d.status;
                rsp_index  <= idx_d;
                rsp_size   <= res_d.size;
                rsp_paddr  <= res_d.paddr;
            end
        end
    end

    // protocol and result checks
    p_resp_follows_r10: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> rsp_vld);

    p_no_spurious_r10: assert property (@(posedge clk) disable iff (rst)
        !req_vld |=> (!rsp_vld && $stable(rsp_paddr) && $stable(rsp_status)));

    p_status_legal_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_vld |-> (rsp_status != 2'd3));

    p_miss_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && rsp_status == ST_MISS) |-> (rsp_index == '0 && rsp_paddr == '0 && rsp_size == '0));

    p_offset_kept_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && rsp_status == ST_HIT)
        |-> (((rsp_paddr ^ $past(req_vaddr)) & ~page_mask(rsp_size)) == '0));

    p_write_right_r7: assert property (@(posedge clk) disable iff (rst)
        (req_vld && found && req_acc == ACC_WRITE && status_d == ST_HIT) |-> eff_wr);

    p_fetch_right_r7: assert property (@(posedge clk) disable iff (rst)
        (req_vld && found && req_acc == ACC_FETCH && status_d == ST_HIT) |-> eff_ex);

endmodule

// File: tb/test_vptlb_xlate.sv
`timescale 1ns/1ps
module test_vptlb_xlate;

    localparam int N  = 64;
    localparam int ZC = 12;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                rst;
    logic                req_vld;
    logic [31:0]         req_vaddr;
    logic [1:0]          req_acc;
    logic                req_user;
    logic [31:0]         cur_pid;
    logic [31:0]         zone_prot;
    logic [N-1:0][31:0]  tbl_tag;
    logic [N-1:0][31:0]  tbl_data;
    logic [N-1:0][7:0]   tbl_tid;

    logic        a_vld, b_vld;
    logic [1:0]  a_st, b_st;
    logic [5:0]  a_idx, b_idx;
    logic [2:0]  a_sz, b_sz;
    logic [31:0] a_pa, b_pa;

    vptlb_xlate #(.NUM_ENTRIES(N), .ZONES_EN(1'b1), .ZONE_COUNT(ZC)) i_vptlb_xlate (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .req_user(req_user), .cur_pid(cur_pid),
        .zone_prot(zone_prot), .ent_tag(tbl_tag), .ent_data(tbl_data),
        .ent_tid(tbl_tid), .rsp_vld(a_vld), .rsp_status(a_st),
        .rsp_index(a_idx), .rsp_size(a_sz), .rsp_paddr(a_pa));

    vptlb_xlate #(.NUM_ENTRIES(N), .ZONES_EN(1'b0), .ZONE_COUNT(ZC)) i_vptlb_xlate_nozone (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .req_user(req_user), .cur_pid(cur_pid),
        .zone_prot(zone_prot), .ent_tag(tbl_tag), .ent_data(tbl_data),
        .ent_tid(tbl_tid), .rsp_vld(b_vld), .rsp_status(b_st),
        .rsp_index(b_idx), .rsp_size(b_sz), .rsp_paddr(b_pa));

    typedef struct {
        logic [1:0]  st;
        logic [5:0]  idx;
        logic [2:0]  sz;
        logic [31:0] pa;
    } exp_t;

    typedef struct {
        string nm;
        exp_t  a;
        exp_t  b;
    } item_t;

    item_t sb[$];
    int n_vec = 0;
    int n_bad = 0;

    // reference search written from the requirements
    function automatic exp_t model(input logic [31:0] va, input logic [1:0] acc,
                                   input logic usr, input bit zen);
        exp_t r;
        r.st = 2'd0; r.idx = '0; r.sz = '0; r.pa = '0;
        for (int i = 0; i < N; i++) begin
            logic [31:0] t, d, bytes, msk;
            logic [1:0]  code;
            logic        wr, ex;
            int          zs;
            t = tbl_tag[i];
            d = tbl_data[i];
            if (!t[6]) continue;
            bytes = 32'd1024 << (2 * int'(t[9:7]));
            msk   = ~(bytes - 32'd1);
            if ((va & msk) != (t & msk)) continue;
            if (tbl_tid[i] != 8'd0 && tbl_tid[i] != cur_pid[7:0]) continue;
            wr   = d[8];
            ex   = d[9];
            zs   = int'(d[7:4]);
            code = 2'((zone_prot >> (30 - 2 * zs)) & 32'd3);
            if (zs > ZC || !zen) code = 2'd1;
            if (code == 2'd0 && usr) continue;
            if ((code == 2'd2 && !usr) || code == 2'd3) begin
                wr = 1'b1;
                ex = 1'b1;
            end
            r.idx = 6'(i);
            r.sz  = t[9:7];
            if ((acc == 2'd1 && !wr) || (acc == 2'd2 && !ex)) begin
                r.st = 2'd2;
                return r;
            end
            r.st = 2'd1;
            r.pa = (d & msk) | (va & ~msk);
            return r;
        end
        return r;
    endfunction

    task automatic clear_table();
        tbl_tag  = '0;
        tbl_data = '0;
        tbl_tid  = '0;
    endtask

    task automatic set_ent(input int i, input logic [31:0] va, input logic [2:0] sz,
                           input logic vld, input logic [7:0] tid, input logic [31:0] rpn,
                           input logic ex, input logic wr, input logic [3:0] zs);
        tbl_tag[i]  = {va[31:10], sz, vld, 6'b0};
        tbl_data[i] = {rpn[31:10], ex, wr, zs, 4'b0};
        tbl_tid[i]  = tid;
    endtask

    function automatic logic [31:0] zone_set(input logic [31:0] z, input int zs,
                                             input logic [1:0] c);
        logic [31:0] r;
        r = z;
        r[31 - 2 * zs -: 2] = c;
        return r;
    endfunction

    task automatic apply(input string nm, input logic [31:0] va,
                         input logic [1:0] acc, input logic usr);
        item_t it;
        @(negedge clk);
        req_vaddr = va;
        req_acc   = acc;
        req_user  = usr;
        req_vld   = 1'b1;
        it.nm = nm;
        it.a  = model(va, acc, usr, 1'b1);
        it.b  = model(va, acc, usr, 1'b0);
        sb.push_back(it);
        @(negedge clk);
        req_vld = 1'b0;
    endtask

    task automatic compare(input string nm, input string which, input exp_t e,
                           input logic [1:0] st, input logic [5:0] idx,
                           input logic [2:0] sz, input logic [31:0] pa);
        n_vec++;
        if (st !== e.st || idx !== e.idx || sz !== e.sz || pa !== e.pa) begin
            n_bad++;
            $display("FAIL %s [%s]: actual st=%0d idx=%0d sz=%0d pa=%h expected st=%0d idx=%0d sz=%0d pa=%h",
                     nm, which, st, idx, sz, pa, e.st, e.idx, e.sz, e.pa);
        end
    endtask

    // monitor: pops one expected item per response
    always @(negedge clk) begin
        if (!rst && (a_vld || b_vld)) begin
            if (sb.size() == 0) begin
                n_vec++;
                n_bad++;
                $display("FAIL R10 unexpected response: actual rsp_vld=%0b/%0b expected 0/0", a_vld, b_vld);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (a_vld !== 1'b1 || b_vld !== 1'b1) begin
                    n_vec++;
                    n_bad++;
                    $display("FAIL R10 %s: actual rsp_vld=%0b/%0b expected 1/1", it.nm, a_vld, b_vld);
                end
                compare(it.nm, "zones", it.a, a_st, a_idx, a_sz, a_pa);
                compare(it.nm, "nozones", it.b, b_st, b_idx, b_sz, b_pa);
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL R10 watchdog: actual still running expected finished");
        summary();
    end

    initial begin
        logic [31:0] zp;
        rst       = 1'b1;
        req_vld   = 1'b0;
        req_vaddr = '0;
        req_acc   = '0;
        req_user  = 1'b0;
        cur_pid   = '0;
        zone_prot = 32'h5555_5555;
        clear_table();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        n_vec++;
        if (a_vld !== 1'b0 || a_st !== 2'd0 || a_idx !== '0 || a_sz !== '0 || a_pa !== '0) begin
            n_bad++;
            $display("FAIL R11 reset: actual vld=%0b st=%0d idx=%0d sz=%0d pa=%h expected all zero",
                     a_vld, a_st, a_idx, a_sz, a_pa);
        end

        apply("R8 empty table miss", 32'h1234_5678, 2'd0, 1'b0);

        // R1 R9 4K page, low real-page bits below the page ignored
        set_ent(5, 32'h1234_5000, 3'd1, 1'b1, 8'd0, 32'hABCD_E400, 1'b1, 1'b1, 4'd0);
        apply("R9 4K hit offset passthrough", 32'h1234_5ABC, 2'd0, 1'b0);
        apply("R2 4K neighbour page miss", 32'h1234_6000, 2'd0, 1'b0);

        // R1 16M page
        set_ent(9, 32'h4500_0000, 3'd7, 1'b1, 8'd0, 32'h8000_0000, 1'b1, 1'b1, 4'd0);
        apply("R1 16M top of page", 32'h45FF_FFF0, 2'd1, 1'b0);
        apply("R1 16M next page miss", 32'h4600_0000, 2'd0, 1'b0);

        // R1 1K page
        set_ent(3, 32'h0000_0400, 3'd0, 1'b1, 8'd0, 32'h7777_7C00, 1'b0, 1'b0, 4'd0);
        apply("R1 1K hit", 32'h0000_07FF, 2'd0, 1'b0);
        apply("R1 1K beyond page miss", 32'h0000_0800, 2'd0, 1'b0);

        // R2 valid flag
        set_ent(3, 32'h0000_0400, 3'd0, 1'b0, 8'd0, 32'h7777_7C00, 1'b1, 1'b1, 4'd0);
        apply("R2 invalid entry skipped", 32'h0000_0500, 2'd0, 1'b0);

        // R3 owner tag
        clear_table();
        set_ent(7, 32'h2000_0000, 3'd2, 1'b1, 8'h22, 32'h3000_0000, 1'b1, 1'b1, 4'd0);
        cur_pid = 32'h0000_0022;
        apply("R3 tid equal hit", 32'h2000_1234, 2'd0, 1'b0);
        cur_pid = 32'h0000_0023;
        apply("R3 tid differ miss", 32'h2000_1234, 2'd0, 1'b0);
        cur_pid = 32'hFFFF_FF22;
        apply("R3 pid upper bits ignored", 32'h2000_1234, 2'd0, 1'b0);
        tbl_tid[7] = 8'h00;
        cur_pid = 32'h0000_0077;
        apply("R3 tid zero matches any", 32'h2000_1234, 2'd0, 1'b0);

        // R6 priority between two overlapping entries
        clear_table();
        cur_pid = 32'h0000_0001;
        set_ent(10, 32'h5000_0000, 3'd1, 1'b1, 8'd0, 32'h6000_0000, 1'b1, 1'b1, 4'd0);
        set_ent(20, 32'h5000_0000, 3'd3, 1'b1, 8'd0, 32'h9000_0000, 1'b1, 1'b1, 4'd1);
        apply("R6 lowest index wins", 32'h5000_0123, 2'd0, 1'b0);
        tbl_tid[10] = 8'h05;
        apply("R6 next candidate after tid reject", 32'h5000_0123, 2'd0, 1'b0);
        tbl_tid[10] = 8'h00;

        // R7 fault stops search
        tbl_data[10][8] = 1'b0;
        apply("R7 write no right fault", 32'h5000_0123, 2'd1, 1'b0);
        apply("R7 read always allowed", 32'h5000_0123, 2'd0, 1'b0);
        apply("R7 acc3 treated as read", 32'h5000_0123, 2'd3, 1'b0);
        tbl_data[10][9] = 1'b0;
        apply("R7 fetch no right fault", 32'h5000_0123, 2'd2, 1'b0);

        // R5 zone code 0 hides from user, entry 20 sits in zone 1 with code 1
        tbl_data[10] = {22'h180000, 1'b0, 1'b0, 4'd2, 4'b0};
        zp = zone_set(32'h5555_5555, 2, 2'd0);
        zone_prot = zp;
        apply("R5 zone0 user skips to later entry", 32'h5000_0123, 2'd0, 1'b1);
        apply("R5 zone0 privileged own rights", 32'h5000_0123, 2'd0, 1'b0);
        apply("R5 zone0 privileged write fault", 32'h5000_0123, 2'd1, 1'b0);

        // R5 zone code 2
        zone_prot = zone_set(32'h5555_5555, 2, 2'd2);
        apply("R5 zone2 privileged write granted", 32'h5000_0123, 2'd1, 1'b0);
        apply("R5 zone2 privileged fetch granted", 32'h5000_0123, 2'd2, 1'b0);
        apply("R5 zone2 user write fault", 32'h5000_0123, 2'd1, 1'b1);

        // R5 zone code 3
        zone_prot = zone_set(32'h5555_5555, 2, 2'd3);
        apply("R5 zone3 user write granted", 32'h5000_0123, 2'd1, 1'b1);
        apply("R5 zone3 user fetch granted", 32'h5000_0123, 2'd2, 1'b1);

        // R4 selector range
        clear_table();
        set_ent(0, 32'hC000_0000, 3'd4, 1'b1, 8'd0, 32'hD000_0000, 1'b0, 1'b1, 4'd12);
        set_ent(1, 32'hE000_0000, 3'd4, 1'b1, 8'd0, 32'hF000_0000, 1'b0, 1'b1, 4'd13);
        zone_prot = zone_set(zone_set(32'h5555_5555, 12, 2'd0), 13, 2'd0);
        apply("R4 in-range zone12 hides user", 32'hC000_1111, 2'd0, 1'b1);
        apply("R4 zone13 above count acts as code1", 32'hE000_1111, 2'd1, 1'b1);
        zone_prot = zone_set(32'h0000_0000, 0, 2'd3);
        tbl_data[0][7:4] = 4'd0;
        apply("R4 zone0 field at top bits", 32'hC000_1111, 2'd2, 1'b1);

        // randomized overlapping tables
        for (int v = 0; v < 300; v++) begin
            clear_table();
            for (int e = 0; e < N; e++) begin
                logic [31:0] base;
                case ($urandom_range(0, 2))
                    0: base = 32'h1000_0000;
                    1: base = 32'h1004_0000;
                    default: base = 32'h2000_0000;
                endcase
                set_ent(e, base | ($urandom & 32'h0003_FC00), 3'($urandom_range(0, 7)),
                        1'($urandom_range(0, 3) == 0), 8'($urandom_range(0, 2)),
                        $urandom, 1'($urandom), 1'($urandom), 4'($urandom));
            end
            cur_pid   = $urandom_range(0, 2);
            zone_prot = $urandom;
            apply("R6 R7 random overlap",
                  (($urandom_range(0, 1) == 0) ? 32'h1000_0000 : 32'h2000_0000) | ($urandom & 32'h000F_FFFF),
                  2'($urandom), 1'($urandom));
        end

        repeat (3) @(negedge clk);
        n_vec++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R10 missing responses: actual %0d pending expected 0", sb.size());
        end
        summary();
    end

endmodule